// File: doc/BRIEF.md
# S/PDIF receiver control and interrupt unit

This unit is the register-facing side of an S/PDIF receiver. Software steers the receiver through a two-bit run mode (off, synchronise only, full reception) and an activity-wait option. The line decoder reports what it sees as single-cycle pulses: parity fault, overrun, start of block, lock achieved, frame error, sync error and timeout. It also hands over received samples and control words with strobes, and reports a measured pulse width.

The unit keeps these events as sticky flags in a status word. It gates the flags with an interrupt-enable register and drives one interrupt line. Flags are cleared in one of three ways. Lock and data-path faults are cleared by a write-one-to-clear register. The two data-ready flags are cleared by reading the register that holds the data. The three line-error flags are cleared by putting the receiver back to off, which is also how software recovers from them. The line decoder and the bus fabric sit outside this block. The register port is a plain address/strobe interface, and read data is a combinational view of the current state.

Top module: `spdif_rx_ctl`

## Requirements
- R1: After reset every register reads zero, `rx_mode` is 00, `sync_en` is 0 and `irq` is 0.
- R2: A write to address 0 loads the run mode from bits [1:0] and the activity-wait bit from bit 2, taking effect on the next cycle. The value 10 in bits [1:0] is ignored and the old mode is kept, while bit 2 is still written. Address 0 reads back {wait, mode} in bits [2:0].
- R3: `smp_stb` loads `smp_word` into address 4 and sets status bit 0. `cw_stb` loads `cw_word` into address 5 and sets status bit 1. A read strobe at address 4 clears bit 0, and a read strobe at address 5 clears bit 1. When a strobe lands in the same cycle as the read, the flag stays set and the new word is held.
- R4: The pulses `ev_perr`, `ev_ovr`, `ev_sbd` and `ev_syncd` set status bits 2, 3, 4 and 5. These bits stay set until cleared.
- R5: A write to address 3 clears each of status bits 2 to 5 whose data bit is one. Every other data bit is ignored. An event in the same cycle keeps its flag set. Address 3 reads zero.
- R6: `ev_ferr`, `ev_serr` and `ev_terr` set status bits 6, 7 and 8, but only while `sync_en` is high. Any cycle whose next mode is 00 clears all three, even if an event arrives in that cycle.
- R7: `sync_en` is high when the mode is not 00 and either the wait bit is 0 or a `line_act` pulse has been seen since the mode left 00. Returning to mode 00 forgets the seen activity.
- R8: A lock event in mode 01 only sets status bit 5. The mode stays 01 until software writes 11.
- R9: `irq` is high when some status bit i (0..5) has enable bit i set at address 1, or when any of status bits 6..8 is set with enable bit 6 set. Address 1 holds enable bits [6:0].
- R10: `wid_stb` captures `wid_val` into status bits [30:16].
- R11: Address 2 is status. Writes to addresses 2, 4 and 5 change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | ADDR_W | Register address |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe (triggers clear-on-read) |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data for `bus_addr` |
| smp_stb | input | 1 | New sample from decoder |
| smp_word | input | DATA_W | Sample value |
| cw_stb | input | 1 | New control word from decoder |
| cw_word | input | DATA_W | Control word value |
| ev_perr | input | 1 | Parity fault pulse |
| ev_ovr | input | 1 | Overrun pulse |
| ev_sbd | input | 1 | Start-of-block pulse |
| ev_syncd | input | 1 | Lock achieved pulse |
| ev_ferr | input | 1 | Frame error pulse |
| ev_serr | input | 1 | Sync error pulse |
| ev_terr | input | 1 | Timeout pulse |
| line_act | input | 1 | Transition seen on the input line |
| wid_stb | input | 1 | Width measurement valid |
| wid_val | input | WID_W | Measured width |
| rx_mode | output | 2 | Current run mode to the decoder |
| sync_en | output | 1 | Decoder may synchronise |
| irq | output | 1 | Interrupt request |

## Verification
Several collisions are provoked on purpose. A sample strobe is driven in the same cycle as a read of the sample register, and the bench expects the ready flag to stay set and the new word to appear. A parity pulse is driven alongside a clear write of that bit, and the bench expects the flag to survive. A timeout pulse is driven together with a write of mode 00, and the bench expects the line-error flag to stay clear. Each outcome is judged by reading the status word and the interrupt line in the cycle after the shared edge.

// File: rtl/spdif_rx_ctl.sv
module spdif_rx_ctl #(
  parameter int ADDR_W  = 3,
  parameter int DATA_W  = 32,
  parameter int WID_W   = 15,
  parameter int WID_LSB = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic              smp_stb,
  input  logic [DATA_W-1:0] smp_word,
  input  logic              cw_stb,
  input  logic [DATA_W-1:0] cw_word,
  input  logic              ev_perr,
  input  logic              ev_ovr,
  input  logic              ev_sbd,
  input  logic              ev_syncd,
  input  logic              ev_ferr,
  input  logic              ev_serr,
  input  logic              ev_terr,
  input  logic              line_act,
  input  logic              wid_stb,
  input  logic [WID_W-1:0]  wid_val,
  output logic [1:0]        rx_mode,
  output logic              sync_en,
  output logic              irq
);
  localparam int NFLAG   = 9;
  localparam int NIEN    = 7;
  localparam int LINE_LO = 6;
  localparam logic [ADDR_W-1:0] A_CTRL  = ADDR_W'(0);
  localparam logic [ADDR_W-1:0] A_IEN   = ADDR_W'(1);
  localparam logic [ADDR_W-1:0] A_STAT  = ADDR_W'(2);
  localparam logic [ADDR_W-1:0] A_CLR   = ADDR_W'(3);
  localparam logic [ADDR_W-1:0] A_DATA  = ADDR_W'(4);
  localparam logic [ADDR_W-1:0] A_CWORD = ADDR_W'(5);

  logic [1:0]        mode_q, mode_nxt;
  logic              wfa_q, act_q;
  logic [NIEN-1:0]   ien_q;
  logic [NFLAG-1:0]  flg, set_v, clr_v, ien_x;
  logic [DATA_W-1:0] smp_q, cw_q;
  logic [WID_W-1:0]  wid_q;
  logic              wr_ctrl, wr_ien, wr_clr, rd_data, rd_cw, go_off;
  logic              unused_wdata;

  assign wr_ctrl = bus_wr && bus_addr == A_CTRL;
  assign wr_ien  = bus_wr && bus_addr == A_IEN;
  assign wr_clr  = bus_wr && bus_addr == A_CLR;
  assign rd_data = bus_rd && bus_addr == A_DATA;
  assign rd_cw   = bus_rd && bus_addr == A_CWORD;
  assign unused_wdata = ^bus_wdata[DATA_W-1:NIEN];

  assign mode_nxt = (wr_ctrl && bus_wdata[1:0] != 2'b10) ? bus_wdata[1:0] : mode_q;
  assign go_off   = mode_nxt == 2'b00;
  assign rx_mode  = mode_q;
  assign sync_en  = (mode_q != 2'b00) && (!wfa_q || act_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= 2'b00;
      wfa_q  <= 1'b0;
      act_q  <= 1'b0;
      ien_q  <= '0;
      smp_q  <= '0;
      cw_q   <= '0;
      wid_q  <= '0;
    end else begin
      mode_q <= mode_nxt;
      if (wr_ctrl) wfa_q <= bus_wdata[2];
      act_q <= go_off ? 1'b0 : (act_q || (line_act && mode_q != 2'b00));
      if (wr_ien)  ien_q <= bus_wdata[NIEN-1:0];
      if (smp_stb) smp_q <= smp_word;
      if (cw_stb)  cw_q  <= cw_word;
      if (wid_stb) wid_q <= wid_val;
    end
  end

  assign set_v = {ev_terr & sync_en, ev_serr & sync_en, ev_ferr & sync_en,
                  ev_syncd, ev_sbd, ev_ovr, ev_perr, cw_stb, smp_stb};
  assign clr_v = {{3{go_off}}, {4{wr_clr}} & bus_wdata[5:2], rd_cw, rd_data};

  for (genvar i = 0; i < NFLAG; i++) begin : g_flag
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        flg[i] <= 1'b0;
      else if (i >= LINE_LO)
        flg[i] <= !clr_v[i] && (flg[i] || set_v[i]);
      else
        flg[i] <= set_v[i] || (flg[i] && !clr_v[i]);
    end
  end

  assign ien_x = {{(NFLAG-LINE_LO){ien_q[NIEN-1]}}, ien_q[LINE_LO-1:0]};
  assign irq   = |(flg & ien_x);

  always_comb begin
    bus_rdata = '0;
    case (bus_addr)
      A_CTRL:  bus_rdata[2:0] = {wfa_q, mode_q};
      A_IEN:   bus_rdata[NIEN-1:0] = ien_q;
      A_STAT: begin
        bus_rdata[NFLAG-1:0] = flg;
        bus_rdata[WID_LSB +: WID_W] = wid_q;
      end
      A_DATA:  bus_rdata = smp_q;
      A_CWORD: bus_rdata = cw_q;
      default: bus_rdata = '0;
    endcase
  end
endmodule

// File: rtl/spdif_rx_ctl_chk.sv
module spdif_rx_ctl_chk #(
  parameter int ADDR_W = 3
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bus_wr,
  input logic [ADDR_W-1:0] bus_addr,
  input logic              smp_stb,
  input logic              ev_perr,
  input logic [8:0]        flags,
  input logic [1:0]        rx_mode,
  input logic              sync_en,
  input logic              irq
);
  // R2
  no_bad_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_mode != 2'b10);
  // R6
  line_clear_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_mode == 2'b00 |-> flags[8:6] == 3'b000);
  // R7
  arm_needs_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sync_en |-> rx_mode != 2'b00);
  // R8
  sync_only_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_mode == 2'b01 && !(bus_wr && bus_addr == '0)) |=> rx_mode == 2'b01);
  // R3
  ready_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    smp_stb |=> flags[0]);
  // R4
  perr_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ev_perr |=> flags[2]);
  // R9
  irq_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> flags != 9'd0);
endmodule

bind spdif_rx_ctl spdif_rx_ctl_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
  .smp_stb(smp_stb), .ev_perr(ev_perr), .flags(flg), .rx_mode(rx_mode),
  .sync_en(sync_en), .irq(irq));

// File: tb/tb_spdif_rx_ctl.sv
`timescale 1ns/1ps
module tb_spdif_rx_ctl;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [2:0]  bus_addr = '0;
  logic        bus_wr = 1'b0, bus_rd = 1'b0;
  logic [31:0] bus_wdata = '0, bus_rdata;
  logic        smp_stb = 1'b0, cw_stb = 1'b0;
  logic [31:0] smp_word = '0, cw_word = '0;
  logic [6:0]  ev = '0;
  logic        line_act = 1'b0, wid_stb = 1'b0;
  logic [14:0] wid_val = '0;
  logic [1:0]  rx_mode;
  logic        sync_en, irq;
  int total = 0, bad = 0;
  logic [31:0] v;

  always #10 clk = ~clk;

  spdif_rx_ctl dut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_rd(bus_rd), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .smp_stb(smp_stb), .smp_word(smp_word), .cw_stb(cw_stb), .cw_word(cw_word),
    .ev_perr(ev[0]), .ev_ovr(ev[1]), .ev_sbd(ev[2]), .ev_syncd(ev[3]),
    .ev_ferr(ev[4]), .ev_serr(ev[5]), .ev_terr(ev[6]), .line_act(line_act),
    .wid_stb(wid_stb), .wid_val(wid_val), .rx_mode(rx_mode),
    .sync_en(sync_en), .irq(irq));

  // {events[6:0] -> status 2..8, enables[6:0], expected irq}
  localparam logic [14:0] VEC [10] = '{
    {7'b0000001, 7'b0000100, 1'b1},
    {7'b0000001, 7'b0001000, 1'b0},
    {7'b0000010, 7'b0001000, 1'b1},
    {7'b0000100, 7'b0010000, 1'b1},
    {7'b0001000, 7'b0100000, 1'b1},
    {7'b0010000, 7'b1000000, 1'b1},
    {7'b0100000, 7'b1000000, 1'b1},
    {7'b1000000, 7'b1000000, 1'b1},
    {7'b1000000, 7'b0111111, 1'b0},
    {7'b0000000, 7'b1111100, 1'b0}
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk); bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk); bus_wr = 1'b0;
  endtask

  task automatic peek(input logic [2:0] a, output logic [31:0] r);
    @(negedge clk); bus_addr = a; #1 r = bus_rdata;
  endtask

  task automatic rdclr(input logic [2:0] a);
    @(negedge clk); bus_addr = a; bus_rd = 1'b1;
    @(negedge clk); bus_rd = 1'b0;
  endtask

  task automatic fire(input logic [6:0] e);
    @(negedge clk); ev = e;
    @(negedge clk); ev = '0;
  endtask

  initial begin
    #4_000_000;
    total++; bad++;
    $display("FAIL watchdog R1 actual=hung expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    #1;
    chk("R1 rx_mode", {30'b0, rx_mode}, 32'd0);
    chk("R1 sync_en", {31'b0, sync_en}, 32'd0);
    chk("R1 irq", {31'b0, irq}, 32'd0);
    for (int a = 0; a < 6; a++) begin
      peek(3'(a), v);
      chk("R1 register", v, 32'd0);
    end

    // R2 mode writes, reserved code
    wr(0, 32'h3);
    #1 chk("R2 mode 11", {30'b0, rx_mode}, 32'd3);
    wr(0, 32'h6);
    #1 chk("R2 reserved kept", {30'b0, rx_mode}, 32'd3);
    peek(0, v); chk("R2 ctrl readback", v, 32'h7);
    wr(0, 32'h1);
    #1 chk("R2 mode 01", {30'b0, rx_mode}, 32'd1);
    wr(0, 32'h0);

    // R10 width capture
    @(negedge clk); wid_val = 15'h5A3C; wid_stb = 1'b1;
    @(negedge clk); wid_stb = 1'b0; wid_val = 15'h7FFF;
    peek(2, v); chk("R10 width", v, {1'b0, 15'h5A3C, 16'h0});

    // R11 writes to read-only registers
    wr(2, 32'hFFFF_FFFF);
    wr(4, 32'h1234_5678);
    wr(5, 32'h1234_5678);
    peek(2, v); chk("R11 status unchanged", v, {1'b0, 15'h5A3C, 16'h0});
    peek(4, v); chk("R11 data unchanged", v, 32'h0);
    peek(5, v); chk("R11 cword unchanged", v, 32'h0);
    peek(3, v); chk("R5 clr reads zero", v, 32'h0);

    // R4 R6 R9 table walk with mode 11, no activity wait
    wr(0, 32'h3);
    for (int i = 0; i < 10; i++) begin
      wr(1, {25'b0, VEC[i][7:1]});
      fire(VEC[i][14:8]);
      peek(2, v);
      chk("R4 flags set", {23'b0, v[8:0]}, {23'b0, VEC[i][14:8], 2'b00});
      chk("R9 irq", {31'b0, irq}, {31'b0, VEC[i][0]});
      wr(3, 32'h3C);
      wr(0, 32'h0);
      wr(0, 32'h3);
      peek(2, v); chk("R6 flags cleared", {23'b0, v[8:0]}, 32'd0);
    end

    // R3 data-ready flags, clear on read, read/strobe collision
    wr(1, 32'h3);
    @(negedge clk); smp_word = 32'hA5A5_0001; smp_stb = 1'b1;
    @(negedge clk); smp_stb = 1'b0;
    #1 chk("R3 irq on ready", {31'b0, irq}, 32'd1);
    peek(4, v); chk("R3 sample word", v, 32'hA5A5_0001);
    rdclr(4);
    peek(2, v); chk("R3 ready cleared", {31'b0, v[0]}, 32'd0);
    #1 chk("R3 irq after read", {31'b0, irq}, 32'd0);
    @(negedge clk); smp_word = 32'h0BAD_F00D; smp_stb = 1'b1;
    @(negedge clk); smp_stb = 1'b0;
    @(negedge clk); bus_addr = 4; bus_rd = 1'b1;
    smp_word = 32'h0000_CAFE; smp_stb = 1'b1;
    @(negedge clk); bus_rd = 1'b0; smp_stb = 1'b0;
    peek(2, v); chk("R3 ready kept on collision", {31'b0, v[0]}, 32'd1);
    peek(4, v); chk("R3 new sample held", v, 32'h0000_CAFE);
    rdclr(4);
    @(negedge clk); cw_word = 32'h0100_00FF; cw_stb = 1'b1;
    @(negedge clk); cw_stb = 1'b0;
    peek(2, v); chk("R3 cword ready", {30'b0, v[1:0]}, 32'd2);
    peek(5, v); chk("R3 cword value", v, 32'h0100_00FF);
    rdclr(5);
    peek(2, v); chk("R3 cword cleared", {30'b0, v[1:0]}, 32'd0);
    wr(1, 32'h0);

    // R5 clear register: other bits ignored, event wins
    fire(7'b0000001);
    wr(3, 32'hFFFF_FFC3);
    peek(2, v); chk("R5 other bits ignored", {31'b0, v[2]}, 32'd1);
    @(negedge clk); bus_addr = 3; bus_wdata = 32'h4; bus_wr = 1'b1; ev = 7'b0000001;
    @(negedge clk); bus_wr = 1'b0; ev = '0;
    peek(2, v); chk("R5 event beats clear", {31'b0, v[2]}, 32'd1);
    wr(3, 32'h4);
    peek(2, v); chk("R5 perr cleared", {31'b0, v[2]}, 32'd0);

    // R6 line errors gated and cleared by off
    wr(0, 32'h0);
    fire(7'b0010000);
    peek(2, v); chk("R6 ferr ignored when off", {31'b0, v[6]}, 32'd0);
    wr(0, 32'h3);
    fire(7'b0100000);
    peek(2, v); chk("R6 serr set", {31'b0, v[7]}, 32'd1);
    wr(0, 32'h0);
    peek(2, v); chk("R6 off clears serr", {31'b0, v[7]}, 32'd0);
    wr(0, 32'h3);
    @(negedge clk); bus_addr = 0; bus_wdata = 32'h0; bus_wr = 1'b1; ev = 7'b1000000;
    @(negedge clk); bus_wr = 1'b0; ev = '0;
    peek(2, v); chk("R6 off beats terr", {31'b0, v[8]}, 32'd0);

    // R7 wait for activity
    wr(0, 32'h5);
    #1 chk("R7 waiting", {31'b0, sync_en}, 32'd0);
    fire(7'b0100000);
    peek(2, v); chk("R7 serr ignored while waiting", {31'b0, v[7]}, 32'd0);
    @(negedge clk); line_act = 1'b1;
    @(negedge clk); line_act = 1'b0;
    #1 chk("R7 armed by activity", {31'b0, sync_en}, 32'd1);
    wr(0, 32'h0);
    wr(0, 32'h5);
    #1 chk("R7 activity forgotten", {31'b0, sync_en}, 32'd0);
    wr(0, 32'h1);
    #1 chk("R7 no wait arms", {31'b0, sync_en}, 32'd1);

    // R8 lock in sync-only mode
    fire(7'b0001000);
    peek(2, v); chk("R8 syncd flag", {31'b0, v[5]}, 32'd1);
    repeat (3) @(negedge clk);
    #1 chk("R8 mode stays 01", {30'b0, rx_mode}, 32'd1);
    wr(0, 32'h3);
    #1 chk("R8 software enters run", {30'b0, rx_mode}, 32'd3);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule